// File: doc/BRIEF.md
# RGB to CMYK Pixel Converter

This block turns one pixel, given as red, green and blue intensities of `W` bits each, into four ink amounts: cyan, magenta, yellow and black. It first inverts each input channel against full scale (`2^W - 1`) to get the raw subtractive colours. It then picks the smallest of those three as the black amount and removes that amount from each raw colour, which leaves the three chromatic inks.

One pixel may be presented on every clock together with a valid strobe. The four results come from a register stage one cycle later with their own valid strobe. When no pixel is presented, the previous result stays on the outputs. The smallest-value selection is a cascade of two two-input stages. Each stage compares its operands by magnitude and uses the "first is greater" result to steer a 2-to-1 multiplexer towards the smaller operand.

Top module: `ink_split`

## Requirements
- R1: While reset is asserted and after its release until the first valid pixel, `outValid` is 0 and all four ink outputs are 0.
- R2: `outValid` in each cycle equals `inValid` of the previous cycle. A pixel accepted at a clock edge appears on the outputs right after that edge.
- R3: For an accepted pixel, `outBlack` equals the minimum of `FULL-inRed`, `FULL-inGreen` and `FULL-inBlue`, with `FULL = 2^W - 1` and all values unsigned.
- R4: For an accepted pixel, `outCyan = (FULL-inRed) - outBlack`, `outMagenta = (FULL-inGreen) - outBlack` and `outYellow = (FULL-inBlue) - outBlack`.
- R5: After every accepted pixel, at least one of `outCyan`, `outMagenta` and `outYellow` is 0.
- R6: No chromatic output ever wraps around: each of `outCyan`, `outMagenta` and `outYellow`, added to `outBlack`, is at most `FULL`.
- R7: In a cycle with `inValid` at 0, the input channels are ignored, and all four ink outputs keep their previous values.
- R8: An all-zero pixel gives `outBlack = FULL` and zero chromatic outputs. An all-ones pixel gives all four outputs 0. A pure primary, with one channel at `FULL` and the others at 0, gives `outBlack = 0` and `FULL` on the other two chromatic outputs.
- R9: A grey pixel (`inRed = inGreen = inBlue = v`) gives `outBlack = FULL - v` and zero chromatic outputs. Ties in the minimum selection therefore need no special handling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Pixel on the colour inputs is to be converted |
| inRed | input | W | Red intensity |
| inGreen | input | W | Green intensity |
| inBlue | input | W | Blue intensity |
| outValid | output | 1 | Ink outputs hold a fresh result |
| outCyan | output | W | Cyan ink after black removal |
| outMagenta | output | W | Magenta ink after black removal |
| outYellow | output | W | Yellow ink after black removal |
| outBlack | output | W | Black ink amount |

## Verification
The bench builds the block twice. One copy uses the default `W = 8` for the named colours (black, white, the primaries, greys) and a pseudo-random pixel stream. The other copy uses `W = 4`, so that all 4096 pixels can be streamed back to back and every ordering and tie among the three raw colours is met. Gaps in the valid strobe are placed in both copies to exercise the hold behaviour and the one-cycle timing of the valid strobe.

// File: rtl/ink_split_pkg.sv
package ink_split_pkg;

  localparam int NUM_CH = 3;

  typedef struct packed {
    logic capture;
  } inkCtl_t;

endpackage

// File: rtl/ink_min2.sv
module ink_min2 #(
  parameter int W = 8
) (
  input  logic [W-1:0] aVal,
  input  logic [W-1:0] bVal,
  output logic [W-1:0] minOut
);

  logic aGtB;

  always_comb begin
    aGtB   = (aVal > bVal);
    minOut = aGtB ? bVal : aVal;
  end

  // R3: the chosen operand is one of the two inputs and no larger than either
  always_comb begin
    a_r3_min_bound: assert ((minOut <= aVal) && (minOut <= bVal));
    a_r3_min_pick:  assert ((minOut == aVal) || (minOut == bVal));
  end

endmodule

// File: rtl/ink_split_ctl.sv
module ink_split_ctl
  import ink_split_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  output inkCtl_t ctl,
  output logic    outValid
);

  logic armed;

  assign ctl.capture = inValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      armed    <= 1'b0;
    end else begin
      outValid <= inValid;
      armed    <= 1'b1;
    end
  end

  // R2: result strobe trails the input strobe by exactly one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (outValid == $past(inValid)));

endmodule

// File: rtl/ink_split_dp.sv
module ink_split_dp
  import ink_split_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  inkCtl_t      ctl,
  input  logic         resultValid,
  input  logic [W-1:0] red,
  input  logic [W-1:0] green,
  input  logic [W-1:0] blue,
  output logic [W-1:0] cyanQ,
  output logic [W-1:0] magentaQ,
  output logic [W-1:0] yellowQ,
  output logic [W-1:0] blackQ
);

  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] rgb    [NUM_CH];
  logic [W-1:0] comp   [NUM_CH];
  logic [W-1:0] chroma [NUM_CH];
  logic [W-1:0] chromaQ[NUM_CH];
  logic [W-1:0] pairMin;
  logic [W-1:0] blackK;

  assign rgb[0] = red;
  assign rgb[1] = green;
  assign rgb[2] = blue;

  // stage 1: invert each channel against full scale
  for (genvar i = 0; i < NUM_CH; i++) begin : g_comp
    assign comp[i] = FULL - rgb[i];
  end

  // stage 2: three-way minimum as a cascade of two pairwise units
  ink_min2 #(.W(W)) u_minFirst (
    .aVal  (comp[0]),
    .bVal  (comp[1]),
    .minOut(pairMin)
  );

  ink_min2 #(.W(W)) u_minSecond (
    .aVal  (pairMin),
    .bVal  (comp[2]),
    .minOut(blackK)
  );

  // stage 3: remove the black share, then register
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chroma
    assign chroma[i] = comp[i] - blackK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           chromaQ[i] <= '0;
      else if (ctl.capture) chromaQ[i] <= chroma[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           blackQ <= '0;
    else if (ctl.capture) blackQ <= blackK;
  end

  assign cyanQ    = chromaQ[0];
  assign magentaQ = chromaQ[1];
  assign yellowQ  = chromaQ[2];

  // R5: the channel that set the black level is left with no chromatic ink
  a_r5_one_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> ((cyanQ == '0) || (magentaQ == '0) || (yellowQ == '0)));

  // R6: chromatic plus black never exceeds full scale
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cyanQ} + {1'b0, blackQ} <= {1'b0, FULL}) &&
    ({1'b0, magentaQ} + {1'b0, blackQ} <= {1'b0, FULL}) &&
    ({1'b0, yellowQ} + {1'b0, blackQ} <= {1'b0, FULL}));

  // R7: with no pixel accepted the results stay put
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.capture |=> ($stable(cyanQ) && $stable(magentaQ) &&
                      $stable(yellowQ) && $stable(blackQ)));

endmodule

// File: rtl/ink_split.sv
module ink_split
  import ink_split_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic [W-1:0] inRed,
  input  logic [W-1:0] inGreen,
  input  logic [W-1:0] inBlue,
  output logic         outValid,
  output logic [W-1:0] outCyan,
  output logic [W-1:0] outMagenta,
  output logic [W-1:0] outYellow,
  output logic [W-1:0] outBlack
);

  inkCtl_t ctl;

  ink_split_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .ctl     (ctl),
    .outValid(outValid)
  );

  ink_split_dp #(.W(W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .resultValid(outValid),
    .red        (inRed),
    .green      (inGreen),
    .blue       (inBlue),
    .cyanQ      (outCyan),
    .magentaQ   (outMagenta),
    .yellowQ    (outYellow),
    .blackQ     (outBlack)
  );

endmodule

// File: tb/ink_split_bench.sv
module ink_split_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // wide copy, default width
  logic       vW;
  logic [7:0] rW, gW, bW;
  logic       ovW;
  logic [7:0] cW, mW, yW, kW;

  ink_split u_ink_split (
    .clk(clk), .rst_n(rst_n), .inValid(vW),
    .inRed(rW), .inGreen(gW), .inBlue(bW),
    .outValid(ovW), .outCyan(cW), .outMagenta(mW),
    .outYellow(yW), .outBlack(kW)
  );

  // narrow copy for the exhaustive sweep
  logic       vN;
  logic [3:0] rN, gN, bN;
  logic       ovN;
  logic [3:0] cN, mN, yN, kN;

  ink_split #(.W(4)) u_ink_split_narrow (
    .clk(clk), .rst_n(rst_n), .inValid(vN),
    .inRed(rN), .inGreen(gN), .inBlue(bN),
    .outValid(ovN), .outCyan(cN), .outMagenta(mN),
    .outYellow(yN), .outBlack(kN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int minOf3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  // checks all four inks of one result against the arithmetic model
  task automatic chkPixel(input string req, input int full, input int r, input int g,
                          input int b, input int c, input int m, input int y, input int k);
    int ec, em, ey, ek;
    ec = full - r; em = full - g; ey = full - b;
    ek = minOf3(ec, em, ey);
    chk({req, " R3 black"}, k, ek);
    chk({req, " R4 cyan"}, c, ec - ek);
    chk({req, " R4 magenta"}, m, em - ek);
    chk({req, " R4 yellow"}, y, ey - ek);
    chk({req, " R5 some zero"}, int'((c == 0) || (m == 0) || (y == 0)), 1);
    chk({req, " R6 no wrap"}, int'((c + k <= full) && (m + k <= full) && (y + k <= full)), 1);
  endtask

  // presents one wide pixel and checks it after the next edge
  task automatic wideOne(input string req, input int r, input int g, input int b);
    @(negedge clk);
    vW = 1'b1; rW = 8'(r); gW = 8'(g); bW = 8'(b);
    @(negedge clk);
    chk({req, " R2 valid"}, int'(ovW), 1);
    chkPixel(req, 255, r, g, b, int'(cW), int'(mW), int'(yW), int'(kW));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    logic [7:0] lfsr;
    int pr, pg, pb;
    vW = 0; rW = 0; gW = 0; bW = 0;
    vN = 0; rN = 0; gN = 0; bN = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(ovW), 0);
    chk("R1 black in reset", int'(kW), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 valid after release", int'(ovW), 0);
    chk("R1 inks after release", int'(cW) + int'(mW) + int'(yW) + int'(kW), 0);
    chk("R1 narrow valid after release", int'(ovN), 0);

    // R8: named colours
    wideOne("R8 black pixel", 0, 0, 0);
    chk("R8 black gives full K", int'(kW), 255);
    wideOne("R8 white pixel", 255, 255, 255);
    chk("R8 white gives zero K", int'(kW), 0);
    wideOne("R8 red", 255, 0, 0);
    chk("R8 red magenta", int'(mW), 255);
    chk("R8 red cyan", int'(cW), 0);
    wideOne("R8 green", 0, 255, 0);
    chk("R8 green yellow", int'(yW), 255);
    wideOne("R8 blue", 0, 0, 255);
    chk("R8 blue cyan", int'(cW), 255);

    // R9: greys
    for (int v = 0; v < 256; v += 51) begin
      wideOne("R9 grey", v, v, v);
      chk("R9 grey K", int'(kW), 255 - v);
      chk("R9 grey chroma", int'(cW) + int'(mW) + int'(yW), 0);
    end

    // R7: inputs change with valid low; outputs hold
    wideOne("R7 setup", 10, 200, 90);
    pr = int'(cW); pg = int'(mW); pb = int'(yW);
    @(negedge clk);
    vW = 1'b0; rW = 8'd3; gW = 8'd250; bW = 8'd77;
    @(negedge clk);
    chk("R2 valid low", int'(ovW), 0);
    @(negedge clk);
    chk("R7 hold black", int'(kW), 255 - 200);
    chk("R7 hold inks", int'(cW) * 65536 + int'(mW) * 256 + int'(yW),
        pr * 65536 + pg * 256 + pb);

    // random stream with back-to-back pixels
    lfsr = 8'hA5;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pr = int'(lfsr);
      pg = int'(lfsr ^ 8'h3C) + n;
      pg = pg % 256;
      pb = int'({lfsr[3:0], lfsr[7:4]});
      wideOne("R3 random", pr, pg, pb);
    end

    // exhaustive narrow sweep; every 7th slot idles
    begin
      int lr, lg, lb;
      bit pend;
      int idx;
      pend = 1'b0; idx = 0; lr = 0; lg = 0; lb = 0;
      for (int r = 0; r < 16; r++)
        for (int g = 0; g < 16; g++)
          for (int b = 0; b < 16; b++) begin
            if ((idx % 7) == 6) begin
              @(negedge clk);
              if (pend) begin
                chk("R2 narrow valid", int'(ovN), 1);
                chkPixel("narrow", 15, lr, lg, lb, int'(cN), int'(mN), int'(yN), int'(kN));
              end
              vN = 1'b0; rN = 4'(b); gN = 4'(r); bN = 4'(g);
              pend = 1'b0;
              @(negedge clk);
              chk("R2 narrow idle", int'(ovN), 0);
              chkPixel("R7 narrow hold", 15, lr, lg, lb, int'(cN), int'(mN), int'(yN), int'(kN));
              vN = 1'b1; rN = 4'(r); gN = 4'(g); bN = 4'(b);
            end else begin
              @(negedge clk);
              if (pend) begin
                chk("R2 narrow valid", int'(ovN), 1);
                chkPixel("narrow", 15, lr, lg, lb, int'(cN), int'(mN), int'(yN), int'(kN));
              end
              vN = 1'b1; rN = 4'(r); gN = 4'(g); bN = 4'(b);
            end
            lr = r; lg = g; lb = b; pend = 1'b1; idx++;
          end
      @(negedge clk);
      vN = 1'b0;
      chkPixel("narrow last", 15, lr, lg, lb, int'(cN), int'(mN), int'(yN), int'(kN));
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule